// File: doc/BRIEF.md
# Integer ALU with Dual-Width Condition Codes

The block is a 64-bit integer arithmetic and logic unit. Its result is produced combinationally from two operands and an opcode. Beside it sits an eight-bit condition-code register that holds two flag groups. The low group describes the result as a 32-bit value and the high group describes it as a 64-bit value. Both groups come from the same 64-bit datapath in the same operation.

The unit supports plain and carry-chained addition and subtraction, and six bitwise operations. The carry-chained forms take their incoming carry or borrow from bit 0 of the condition-code register. The register loads on a clock edge only when the set-flags input is high and the opcode is defined. A pipeline can therefore chain wide arithmetic by issuing one carry-chained operation per cycle with set-flags held high.

Top module: `int_alu_dual`

## Requirements
- R1: Opcode 0 (add) gives a+b modulo 2^64; opcode 1 (add with carry) gives a+b+flags[0].
- R2: Opcode 2 (subtract) gives a-b modulo 2^64; opcode 3 (subtract with borrow) gives a+~b+1-flags[0].
- R3: Opcodes 4..9 give a&b, a|b, a^b, a|~b, a&~b and ~(a^b) respectively.
- R4: The flag byte is {N64,Z64,V64,C64,N32,Z32,V32,C32} from bit 7 down to bit 0. N32 is result bit 31 and N64 is result bit 63. Z32 is set when result bits 31..0 are all zero, and Z64 is set when all 64 bits are zero.
- R5: For opcodes 0 and 1, C32 is the carry out of the 32-bit sum of the low halves plus the carry-in, and C64 is the carry out of the full 64-bit sum.
- R6: For opcodes 2 and 3, C32 and C64 hold the borrow out of the 32-bit and 64-bit unsigned subtraction, which is the inverse of the adder carry-out.
- R7: For opcodes 0 and 1, V32 (V64) is set when a and b have equal bit 31 (bit 63) and the result's bit differs from it.
- R8: For opcodes 2 and 3, V32 (V64) is set when a and b differ in bit 31 (bit 63) and the result's bit differs from a's.
- R9: Opcodes 4..9 clear V and C in both groups.
- R10: The flag register loads on the rising clock edge only when set_flags is 1 and the opcode is defined. Otherwise it keeps its value.
- R11: Opcodes 10..15 drive the result to zero and never change the flags.
- R12: An active-low reset clears all eight flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opnd_a | input | 64 | First operand |
| opnd_b | input | 64 | Second operand |
| op | input | 4 | Operation code |
| set_flags | input | 1 | Load the flag register at the next edge |
| result | output | 64 | Combinational result |
| flags | output | 8 | Registered condition codes |

## Verification
Two things can happen in the same cycle: reading the carry-in from flags[0] and overwriting the flag register. This occurs when a carry-chained add or subtract runs with set_flags high. The bench provokes it with back-to-back chains of opcodes 1 and 3 over operand pairs that carry or borrow at bit 31 and bit 63. Its model computes each result from the flags held before the edge and applies the new flags only after that edge. A design that fed the new carry into the same cycle's sum would therefore disagree on the result.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADDC = 4'd1,
        OP_SUB  = 4'd2,
        OP_SUBC = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_ORN  = 4'd7,
        OP_ANDN = 4'd8,
        OP_XNOR = 4'd9
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } cc_grp_t;

    localparam int unsigned GROUPS = 2;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W  = 64,
    parameter int LW = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  logic         chain_bit,
    output logic [W-1:0] sum,
    output logic         co_lo,
    output logic         co_hi
);
    localparam int HW = W - LW;

    logic [W-1:0]  b_eff;
    logic          cin;
    logic [LW:0]   lo;
    logic [HW:0]   hi;

    // Subtraction: invert b and complement the incoming borrow.
    always_comb begin
        b_eff = sub ? ~b : b;
        cin   = sub ? ~chain_bit : chain_bit;
        lo    = {1'b0, a[LW-1:0]} + {1'b0, b_eff[LW-1:0]} + {{LW{1'b0}}, cin};
        hi    = {1'b0, a[W-1:LW]} + {1'b0, b_eff[W-1:LW]} + {{HW{1'b0}}, lo[LW]};
        sum   = {hi[HW-1:0], lo[LW-1:0]};
        co_lo = lo[LW];
        co_hi = hi[HW];
    end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_pkg::*;
#(
    parameter int W = 64
) (
    input  alu_op_e      opc,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    always_comb begin
        unique case (opc)
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_ORN:  y = a | ~b;
            OP_ANDN: y = a & ~b;
            OP_XNOR: y = ~(a ^ b);
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/alu_ccgen.sv
module alu_ccgen
    import alu_pkg::*;
#(
    parameter int W  = 64,
    parameter int LW = 32
) (
    input  logic [W-1:0]       a,
    input  logic [W-1:0]       b,
    input  logic [W-1:0]       res,
    input  logic               arith,
    input  logic               sub,
    input  logic               co_lo,
    input  logic               co_hi,
    output cc_grp_t [GROUPS-1:0] grp
);
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        localparam int TOP = (g == 0) ? LW : W;
        localparam int MSB = TOP - 1;

        logic co;
        logic same_sign;
        logic res_flip;

        assign co        = (g == 0) ? co_lo : co_hi;
        assign same_sign = (a[MSB] == b[MSB]);
        assign res_flip  = (res[MSB] != a[MSB]);

        always_comb begin
            grp[g].n = res[MSB];
            grp[g].z = ~|res[MSB:0];
            grp[g].v = arith & res_flip & (sub ? ~same_sign : same_sign);
            grp[g].c = arith & (sub ? ~co : co);
        end
    end
endmodule

// File: rtl/int_alu_dual.sv
module int_alu_dual
    import alu_pkg::*;
#(
    parameter int W  = 64,
    parameter int LW = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic [3:0]   op,
    input  logic         set_flags,
    output logic [W-1:0] result,
    output logic [7:0]   flags
);
    alu_op_e              opc;
    logic                 is_arith;
    logic                 is_sub;
    logic                 is_logic;
    logic                 use_chain;
    logic [W-1:0]         sum;
    logic [W-1:0]         logic_y;
    logic                 co_lo;
    logic                 co_hi;
    cc_grp_t [GROUPS-1:0] grp;
    logic [7:0]           flags_q;

    assign opc = alu_op_e'(op);

    always_comb begin
        is_arith  = 1'b0;
        is_sub    = 1'b0;
        is_logic  = 1'b0;
        use_chain = 1'b0;
        unique case (opc)
            OP_ADD:  is_arith = 1'b1;
            OP_ADDC: begin is_arith = 1'b1; use_chain = 1'b1; end
            OP_SUB:  begin is_arith = 1'b1; is_sub = 1'b1; end
            OP_SUBC: begin is_arith = 1'b1; is_sub = 1'b1; use_chain = 1'b1; end
            OP_AND, OP_OR, OP_XOR, OP_ORN, OP_ANDN, OP_XNOR: is_logic = 1'b1;
            default: ;
        endcase
    end

    alu_addsub #(.W(W), .LW(LW)) u_addsub (
        .a         (opnd_a),
        .b         (opnd_b),
        .sub       (is_sub),
        .chain_bit (use_chain & flags_q[0]),
        .sum       (sum),
        .co_lo     (co_lo),
        .co_hi     (co_hi)
    );

    alu_logic #(.W(W)) u_logic (
        .opc (opc),
        .a   (opnd_a),
        .b   (opnd_b),
        .y   (logic_y)
    );

    always_comb begin
        if (is_arith)      result = sum;
        else if (is_logic) result = logic_y;
        else               result = '0;
    end

    alu_ccgen #(.W(W), .LW(LW)) u_cc (
        .a     (opnd_a),
        .b     (opnd_b),
        .res   (result),
        .arith (is_arith),
        .sub   (is_sub),
        .co_lo (co_lo),
        .co_hi (co_hi),
        .grp   (grp)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flags_q <= '0;
        else if (set_flags && (is_arith || is_logic))
            flags_q <= {grp[1], grp[0]};
    end

    assign flags = flags_q;
endmodule

// File: rtl/alu_chk.sv
module alu_chk #(
    parameter int W  = 64,
    parameter int LW = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] opnd_a,
    input logic [W-1:0] opnd_b,
    input logic [3:0]   op,
    input logic         set_flags,
    input logic [W-1:0] result,
    input logic [7:0]   flags
);
    assert_reset_clear_R12: assert property (@(posedge clk)
        !rst_n |=> flags == 8'h00);

    assert_hold_no_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !set_flags |=> flags == $past(flags));

    assert_undef_no_flags_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (op > 4'd9) |=> flags == $past(flags));

    assert_undef_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (op > 4'd9) |-> result == '0);

    assert_add_sum_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 4'd0) |-> result == opnd_a + opnd_b);

    assert_logic_clears_vc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (set_flags && op >= 4'd4 && op <= 4'd9) |=> (flags[5:4] == 2'b00 && flags[1:0] == 2'b00));

    assert_sign_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (set_flags && op <= 4'd9) |=> (flags[7] == $past(result[W-1]) && flags[3] == $past(result[LW-1])));

    assert_sub_borrow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (set_flags && op == 4'd2) |=> flags[4] == ($past(opnd_a) < $past(opnd_b)));
endmodule

bind int_alu_dual alu_chk #(.W(W), .LW(LW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .op        (op),
    .set_flags (set_flags),
    .result    (result),
    .flags     (flags)
);

// File: tb/int_alu_dual_tb.sv
module int_alu_dual_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] a = '0;
    logic [63:0] b = '0;
    logic [3:0]  op = '0;
    logic        set_flags = 1'b0;
    logic [63:0] result;
    logic [7:0]  flags;

    int     n_chk = 0;
    int     n_err = 0;
    logic [7:0] mflags = '0;
    string  ftag = "R12";

    always #4 clk = ~clk;

    int_alu_dual u_dut (
        .clk (clk), .rst_n (rst_n), .opnd_a (a), .opnd_b (b),
        .op (op), .set_flags (set_flags), .result (result), .flags (flags)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural reference: wide signed/unsigned arithmetic.
    task automatic model(input logic [3:0] o, input logic [63:0] x, input logic [63:0] y,
                         input logic c, output logic [63:0] r, output logic [7:0] nf,
                         output bit ok_op);
        logic [64:0] w;
        logic [32:0] l;
        logic signed [65:0] sw;
        logic signed [33:0] sl;
        logic v64, v32, c64, c32, ci;
        v64 = 0; v32 = 0; c64 = 0; c32 = 0; ok_op = 1;
        ci = (o == 4'd1 || o == 4'd3) ? c : 1'b0;
        case (o)
            4'd0, 4'd1: begin
                w  = {1'b0, x} + {1'b0, y} + 65'(ci);
                l  = {1'b0, x[31:0]} + {1'b0, y[31:0]} + 33'(ci);
                sw = $signed({{2{x[63]}}, x}) + $signed({{2{y[63]}}, y}) + 66'(ci);
                sl = $signed({{2{x[31]}}, x[31:0]}) + $signed({{2{y[31]}}, y[31:0]}) + 34'(ci);
                r = w[63:0]; c64 = w[64]; c32 = l[32];
                v64 = (sw > 66'sh7FFF_FFFF_FFFF_FFFF) || (sw < -66'sh8000_0000_0000_0000);
                v32 = (sl > 34'sh7FFF_FFFF) || (sl < -34'sh8000_0000);
            end
            4'd2, 4'd3: begin
                w  = {1'b0, x} - {1'b0, y} - 65'(ci);
                l  = {1'b0, x[31:0]} - {1'b0, y[31:0]} - 33'(ci);
                sw = $signed({{2{x[63]}}, x}) - $signed({{2{y[63]}}, y}) - 66'(ci);
                sl = $signed({{2{x[31]}}, x[31:0]}) - $signed({{2{y[31]}}, y[31:0]}) - 34'(ci);
                r = w[63:0]; c64 = w[64]; c32 = l[32];
                v64 = (sw > 66'sh7FFF_FFFF_FFFF_FFFF) || (sw < -66'sh8000_0000_0000_0000);
                v32 = (sl > 34'sh7FFF_FFFF) || (sl < -34'sh8000_0000);
            end
            4'd4: r = x & y;
            4'd5: r = x | y;
            4'd6: r = x ^ y;
            4'd7: r = x | ~y;
            4'd8: r = x & ~y;
            4'd9: r = ~(x ^ y);
            default: begin r = '0; ok_op = 0; end
        endcase
        nf = {r[63], (r == 64'd0), v64, c64, r[31], (r[31:0] == 32'd0), v32, c32};
    endtask

    task automatic step(input logic [3:0] o, input logic [63:0] x, input logic [63:0] y, input logic s);
        logic [63:0] er;
        logic [7:0]  nf;
        bit          ok_op;
        string       rtag;
        @(negedge clk);
        chk(flags == mflags, ftag, 64'(flags), 64'(mflags));
        op = o; a = x; b = y; set_flags = s;
        model(o, x, y, mflags[0], er, nf, ok_op);
        #1;
        if (o <= 4'd1)      rtag = "R1";
        else if (o <= 4'd3) rtag = "R2";
        else if (o <= 4'd9) rtag = "R3";
        else                rtag = "R11";
        chk(result == er, rtag, result, er);
        @(posedge clk);
        if (s && ok_op) mflags = nf;
        if (!s)             ftag = "R10";
        else if (!ok_op)    ftag = "R11";
        else if (o <= 4'd1) ftag = "R4 R5 R7";
        else if (o <= 4'd3) ftag = "R4 R6 R8";
        else                ftag = "R4 R9";
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(flags == 8'h00, "R12", 64'(flags), 64'h0);
        rst_n = 1'b1;
        // R5 carry at bit 31 only; R7 overflow at bit 31
        step(4'd0, 64'h0000_0000_FFFF_FFFF, 64'h1, 1'b1);
        step(4'd0, 64'h0000_0000_7FFF_FFFF, 64'h1, 1'b1);
        step(4'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1'b1);
        step(4'd0, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 1'b1);
        // R1 chained add consumes C32
        step(4'd0, 64'hFFFF_FFFF, 64'hFFFF_FFFF, 1'b1);
        step(4'd1, 64'h10, 64'h20, 1'b1);
        step(4'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b1);
        // R6 borrow, R8 overflow
        step(4'd2, 64'h5, 64'h5, 1'b1);
        step(4'd2, 64'h0, 64'h1, 1'b1);
        step(4'd3, 64'h7, 64'h7, 1'b1);
        step(4'd3, 64'h7, 64'h7, 1'b1);
        step(4'd2, 64'h8000_0000_0000_0000, 64'h1, 1'b1);
        step(4'd2, 64'h0000_0000_8000_0000, 64'h1, 1'b1);
        // R10 hold with set_flags low
        step(4'd2, 64'h0, 64'h1, 1'b0);
        step(4'd1, 64'h1, 64'h1, 1'b0);
        // R3, R9 logic
        step(4'd4, 64'hF0F0_0000_FFFF_0000, 64'hFF00_FF00_FF00_0000, 1'b1);
        step(4'd5, 64'h0, 64'h0, 1'b1);
        step(4'd6, 64'hAAAA, 64'hAAAA, 1'b1);
        step(4'd7, 64'h1, 64'hFFFF_FFFF_0000_0000, 1'b1);
        step(4'd8, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_8000_0000, 1'b1);
        step(4'd9, 64'h1234, 64'h1234, 1'b1);
        // R11 undefined codes
        step(4'd2, 64'h0, 64'h1, 1'b1);
        for (int k = 10; k < 16; k++) step(4'(k), 64'hFFFF, 64'h1, 1'b1);
        // Chains mixing flag read and flag write in the same cycle
        for (int i = 0; i < 400; i++) begin
            logic [3:0] ro;
            logic [63:0] ra, rb;
            ro = 4'($urandom_range(0, 15));
            ra = {$urandom, $urandom};
            rb = {$urandom, $urandom};
            if (i % 3 == 0) begin ra[31:0] = 32'hFFFF_FFFF; ro = 4'($urandom_range(0, 3)); end
            step(ro, ra, rb, ($urandom_range(0, 3) != 0));
        end
        @(negedge clk);
        chk(flags == mflags, ftag, 64'(flags), 64'(mflags));
        summary();
        $finish;
    end
endmodule